// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that software reaches through three word-addressed registers: a control/status word, a counter word and a timeout word. Writes to the counter word are not data. Each one is read as a command key. One key pair opens a short unlock window in which the configuration may be changed. A second key pair restarts the count from zero. Any other value written there counts as a fault.

While counting is enabled, the counter advances by one on each cycle in which the slow `tick` input is high. A low-power wait or stop indication pauses the count unless the matching run-in-mode bit is set. When the enabled counter reaches the timeout value, or when a bad key arrives, the block raises `rst_req`. That request stays high until the block itself is reset.

Keys arrive either as two 16-bit halves in two writes, or as one 32-bit word when the wide-command bit is set. After a reconfiguration that clears the update-allow bit, no further unlock is accepted, so the configuration stays fixed until reset.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the control word reads 0x0120 (tick select 1, update-allow set, all other bits clear), the counter reads 0, the timeout reads TOV_INIT and `rst_req` is low.
- R2: While the unlock flag (control bit 11) is clear, writes to the control word (offset 0x0) and to the timeout word (offset 0x8) leave both registers unchanged.
- R3: Writing 0xC520 and then 0xD928 to the counter word (offset 0x4) sets control bit 11 once the second write completes. When control bit 13 is set, one write of 0xD928C520 does the same.
- R4: The unlock flag stays set for exactly WIN_CYC clock cycles after the accepting write. It clears earlier on the cycle after one accepted configuration write.
- R5: A configuration write accepted while unlocked shows in its register on the next cycle and sets control bit 10. Bit 10 clears again when the next unlock key is accepted. The fields are: bit 13 wide command, bits 9:8 tick select, bit 7 count enable, bit 5 update allow, bit 1 run in wait, bit 0 run in stop.
- R6: The refresh key clears the counter to 0 on the cycle after the write completes. In 16-bit mode the key is 0xA602 followed by 0xB480. In wide mode it is the single word 0xB480A602.
- R7: With bit 7 set, the counter advances by one per cycle with `tick` high. `lp_wait` pauses it unless bit 1 is set, and `lp_stop` pauses it unless bit 0 is set.
- R8: `rst_req` rises one cycle after the enabled counter first equals or exceeds the timeout value, and it stays high until `rst_n` is asserted.
- R9: A counter-word write that starts no key, a second half that does not complete the pending key, or any non-key word in wide mode raises `rst_req` on the cycle after the write.
- R10: After an accepted configuration write that leaves bit 5 clear, unlock keys are ignored without raising a fault, and the registers stay unchanged until reset.
- R11: In 16-bit mode the upper 16 bits of a counter-word write are ignored when keys are decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow count enable, one cycle per tick |
| lp_wait | input | 1 | Chip is in low-power wait |
| lp_stop | input | 1 | Chip is in low-power stop |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte offset of the register accessed |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The hardest states to reach are the ones that depend on a chain of earlier accepted writes. One is the locked-out condition: it needs an unlock, then a configuration write that clears update-allow, and only then a second key pair that must be silently refused. Another is a key fault in wide mode, which needs the wide-command bit to be set inside an earlier unlock window first. The stimulus builds these chains as directed sequences. It then repeats the unlock, timeout, enable and count path with timeouts, tick counts and upper key bits drawn from a seeded `$urandom`, and the bench predicts the counter and reset outcome for each draw.

// File: rtl/kwd_pkg.sv
// Shared constants and types for the key-protected watchdog.
// Assumes byte offsets on a word-aligned register interface.
package kwd_pkg;
    localparam logic [15:0] UNL_LO = 16'hC520;
    localparam logic [15:0] UNL_HI = 16'hD928;
    localparam logic [15:0] REF_LO = 16'hA602;
    localparam logic [15:0] REF_HI = 16'hB480;

    localparam int OFS_CTL = 0;
    localparam int OFS_CNT = 4;
    localparam int OFS_TOV = 8;

    localparam int B_CMD32 = 13;
    localparam int B_ULK   = 11;
    localparam int B_RCS   = 10;
    localparam int B_SEL   = 8;
    localparam int B_EN    = 7;
    localparam int B_UPD   = 5;
    localparam int B_WT    = 1;
    localparam int B_ST    = 0;

    typedef enum logic [1:0] {KS_IDLE, KS_UNL, KS_REF} kseq_t;

    typedef struct packed {
        logic       cmd32;
        logic [1:0] sel;
        logic       en;
        logic       upd;
        logic       wt_en;
        logic       st_en;
    } cfg_t;
endpackage

// File: rtl/kwd_keyseq.sv
// Decodes counter-word writes into unlock, refresh or fault pulses.
// Assumes key_wr is a single-cycle strobe; the pulses are combinational.
module kwd_keyseq
    import kwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    input  logic        cmd32,
    output logic        unlock_hit,
    output logic        refresh_hit,
    output logic        key_fault
);
    kseq_t       st, st_nxt;
    logic [15:0] lo;

    assign lo = key_data[15:0];

    // Next pending-half state and the command pulses.
    always_comb begin
        st_nxt      = st;
        unlock_hit  = 1'b0;
        refresh_hit = 1'b0;
        key_fault   = 1'b0;
        if (key_wr) begin
            if (cmd32) begin
                st_nxt = KS_IDLE;
                if (key_data == {UNL_HI, UNL_LO})      unlock_hit  = 1'b1;
                else if (key_data == {REF_HI, REF_LO}) refresh_hit = 1'b1;
                else                                   key_fault   = 1'b1;
            end else begin
                case (st)
                    KS_IDLE: begin
                        if (lo == UNL_LO)      st_nxt = KS_UNL;
                        else if (lo == REF_LO) st_nxt = KS_REF;
                        else                   key_fault = 1'b1;
                    end
                    KS_UNL: begin
                        st_nxt = KS_IDLE;
                        if (lo == UNL_HI) unlock_hit = 1'b1;
                        else              key_fault  = 1'b1;
                    end
                    default: begin
                        st_nxt = KS_IDLE;
                        if (lo == REF_HI) refresh_hit = 1'b1;
                        else              key_fault   = 1'b1;
                    end
                endcase
            end
        end
    end

    // Hold which first half, if any, is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= KS_IDLE;
        else        st <= st_nxt;
    end

    assert_one_command_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({unlock_hit, refresh_hit, key_fault}));
    assert_no_write_no_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |-> !(unlock_hit || refresh_hit || key_fault));
endmodule

// File: rtl/kwd_unlock.sv
// Unlock window timer, reconfiguration-done flag and the lock-out latch.
// Assumes WIN_CYC >= 2 and that unlock_hit and cfg_wr never coincide.
module kwd_unlock #(
    parameter int WIN_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic unlock_hit,
    input  logic cfg_wr,
    input  logic upd_next,
    output logic ulk,
    output logic rcs,
    output logic frozen
);
    localparam int WW = $clog2(WIN_CYC) + 1;
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYC - 1);

    logic [WW-1:0] win;

    // Open, run down and close the unlock window; record reconfiguration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ulk    <= 1'b0;
            win    <= '0;
            rcs    <= 1'b0;
            frozen <= 1'b0;
        end else if (unlock_hit && !frozen) begin
            ulk <= 1'b1;
            win <= WIN_LAST;
            rcs <= 1'b0;
        end else if (ulk) begin
            if (cfg_wr) begin
                ulk    <= 1'b0;
                rcs    <= 1'b1;
                frozen <= !upd_next;
            end else if (win == '0) begin
                ulk <= 1'b0;
            end else begin
                win <= win - 1'b1;
            end
        end
    end

    assert_window_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ulk && cfg_wr) |=> (!ulk && rcs));
    assert_frozen_stays_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !ulk) |=> (!ulk && frozen));
    assert_unlock_clears_rcs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_hit && !frozen) |=> (ulk && !rcs));
endmodule

// File: rtl/kwd_count.sv
// Tick-driven watchdog counter with refresh and timeout compare.
// Assumes run already folds in the enable and the low-power gating.
module kwd_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          en,
    input  logic          refresh,
    input  logic [CW-1:0] toval,
    output logic [CW-1:0] cnt,
    output logic          expired
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    // Count ticks, saturating, and clear on refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)                             cnt <= '0;
        else if (refresh)                       cnt <= '0;
        else if (tick && run && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // Flag that the enabled counter has reached the timeout value.
    always_comb expired = en && (cnt >= toval);

    assert_refresh_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (cnt == '0));
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh |=> (cnt == $past(cnt) || cnt == CW'($past(cnt) + 1'b1)));
    assert_no_run_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh && !run) |=> $stable(cnt));
endmodule

// File: rtl/keyed_wdog.sv
// Key-protected watchdog: register file, key decode, unlock window,
// counter and sticky reset request. Assumes CW <= 32 and a write strobe
// of one cycle per access; reads are combinational from addr.
module keyed_wdog
    import kwd_pkg::*;
#(
    parameter int          AW       = 4,
    parameter int          CW       = 16,
    parameter int          WIN_CYC  = 256,
    parameter int unsigned TOV_INIT = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          lp_wait,
    input  logic          lp_stop,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wr_data,
    output logic [31:0]   rd_data,
    output logic          rst_req
);
    localparam cfg_t CFG_RST = '{cmd32: 1'b0, sel: 2'd1, en: 1'b0, upd: 1'b1,
                                 wt_en: 1'b0, st_en: 1'b0};
    localparam logic [AW-1:0] A_CTL = AW'(OFS_CTL);
    localparam logic [AW-1:0] A_CNT = AW'(OFS_CNT);
    localparam logic [AW-1:0] A_TOV = AW'(OFS_TOV);

    cfg_t          cfg;
    logic [CW-1:0] toval, cnt;
    logic          ulk, rcs, frozen;
    logic          unlock_hit, refresh_hit, key_fault, expired;
    logic          wr_ctl, wr_tov, take_ctl, take_tov, upd_next, run;

    assign wr_ctl   = wr_en && addr == A_CTL;
    assign wr_tov   = wr_en && addr == A_TOV;
    assign take_ctl = wr_ctl && ulk;
    assign take_tov = wr_tov && ulk;
    assign upd_next = take_ctl ? wr_data[B_UPD] : cfg.upd;

    kwd_keyseq u_keys (
        .clk(clk), .rst_n(rst_n),
        .key_wr(wr_en && addr == A_CNT), .key_data(wr_data), .cmd32(cfg.cmd32),
        .unlock_hit(unlock_hit), .refresh_hit(refresh_hit), .key_fault(key_fault)
    );

    kwd_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
        .clk(clk), .rst_n(rst_n), .unlock_hit(unlock_hit),
        .cfg_wr(take_ctl || take_tov), .upd_next(upd_next),
        .ulk(ulk), .rcs(rcs), .frozen(frozen)
    );

    // Counting is gated by enable and by the low-power mode permissions.
    always_comb run = cfg.en && !(lp_wait && !cfg.wt_en) && !(lp_stop && !cfg.st_en);

    kwd_count #(.CW(CW)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .en(cfg.en),
        .refresh(refresh_hit), .toval(toval), .cnt(cnt), .expired(expired)
    );

    // Load the configuration word only inside the unlock window.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg <= CFG_RST;
        else if (take_ctl)
            cfg <= '{cmd32: wr_data[B_CMD32], sel: wr_data[B_SEL+1:B_SEL],
                     en: wr_data[B_EN], upd: wr_data[B_UPD],
                     wt_en: wr_data[B_WT], st_en: wr_data[B_ST]};
    end

    // Load the timeout value only inside the unlock window.
    always_ff @(posedge clk) begin
        if (!rst_n)        toval <= CW'(TOV_INIT);
        else if (take_tov) toval <= wr_data[CW-1:0];
    end

    // Latch a reset request on expiry or key fault until system reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rst_req <= 1'b0;
        else if (expired || key_fault)  rst_req <= 1'b1;
    end

    // Return the register selected by addr.
    always_comb begin
        rd_data = '0;
        case (addr)
            A_CTL: begin
                rd_data[B_CMD32]       = cfg.cmd32;
                rd_data[B_ULK]         = ulk;
                rd_data[B_RCS]         = rcs;
                rd_data[B_SEL+1:B_SEL] = cfg.sel;
                rd_data[B_EN]          = cfg.en;
                rd_data[B_UPD]         = cfg.upd;
                rd_data[B_WT]          = cfg.wt_en;
                rd_data[B_ST]          = cfg.st_en;
            end
            A_CNT:   rd_data[CW-1:0] = cnt;
            A_TOV:   rd_data[CW-1:0] = toval;
            default: rd_data = '0;
        endcase
    end

    assert_locked_tov_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tov && !ulk) |=> $stable(toval));
    assert_locked_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !ulk) |=> $stable(cfg));
    assert_req_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
    assert_fault_trips_R9: assert property (@(posedge clk) disable iff (!rst_n)
        key_fault |=> rst_req);
    assert_expiry_trips_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && cnt >= toval) |=> rst_req);
endmodule

// File: tb/keyed_wdog_test.sv
module keyed_wdog_test;
    localparam int AW = 4, CW = 16, WIN = 32, TOV0 = 1000;

    logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic          lp_wait = 1'b0, lp_stop = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wr_data = '0, rd_data;
    logic          rst_req;
    int            checks = 0, errors = 0;
    bit            done = 1'b0;

    keyed_wdog #(.AW(AW), .CW(CW), .WIN_CYC(WIN), .TOV_INIT(TOV0)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lp_wait(lp_wait), .lp_stop(lp_stop),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .rst_req(rst_req)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] ctl_word(bit c32, bit ul, bit rc, bit en, bit upd,
                                             bit wt, bit st);
        return (32'(c32) << 13) | (32'(ul) << 11) | (32'(rc) << 10) | (32'd1 << 8) |
               (32'(en) << 7) | (32'(upd) << 5) | (32'(wt) << 1) | 32'(st);
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] v);
        addr = AW'(a);
        #1 v = rd_data;
    endtask

    task automatic ticks(int n);
        @(negedge clk);
        repeat (n) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lp_wait = 1'b0; lp_stop = 1'b0; tick = 1'b0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    task automatic unlock16();
        wr(4, {16'($urandom), 16'hC520});
        wr(4, {16'($urandom), 16'hD928});
    endtask

    task automatic refresh16();
        wr(4, 32'h0000A602);
        wr(4, 32'h0000B480);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, bad;
        int t, n;
        void'($urandom(32'h5EED_0042));
        do_reset();

        // R1 reset state
        rd(0, v); chk("R1 ctl", v, 32'h0120);
        rd(4, v); chk("R1 cnt", v, 0);
        rd(8, v); chk("R1 tov", v, TOV0);
        chk("R1 rst_req", 32'(rst_req), 0);

        // R2 locked writes ignored
        wr(8, 32'd7);      rd(8, v); chk("R2 tov locked", v, TOV0);
        wr(0, 32'h0000_2083); rd(0, v); chk("R2 ctl locked", v, 32'h0120);

        // R3 + R11 unlock with random upper bits
        unlock16(); rd(0, v); chk("R3 R11 unlock16", v, ctl_word(0,1,0,0,1,0,0));

        // R5 + R4 timeout write closes window
        wr(8, 32'd9); rd(8, v); chk("R5 tov load", v, 9);
        rd(0, v); chk("R4 R5 closed and rcs", v, ctl_word(0,0,1,0,1,0,0));

        // R4 window expiry, R5 rcs cleared by unlock
        unlock16();
        rd(0, v); chk("R5 rcs cleared", v, ctl_word(0,1,0,0,1,0,0));
        cyc(WIN - 1); rd(0, v); chk("R4 still open", v, ctl_word(0,1,0,0,1,0,0));
        cyc(1);       rd(0, v); chk("R4 expired", v, ctl_word(0,0,0,0,1,0,0));
        wr(8, 32'd3); rd(8, v); chk("R2 after expiry", v, 9);

        // R7 counting, low-power gating, R6 refresh
        unlock16(); wr(0, 32'h01A0);
        rd(0, v); chk("R5 ctl load", v, ctl_word(0,0,1,1,1,0,0));
        ticks(4); rd(4, v); chk("R7 count", v, 4);
        lp_wait = 1'b1; ticks(3); lp_wait = 1'b0;
        rd(4, v); chk("R7 wait pause", v, 4);
        refresh16(); rd(4, v); chk("R6 refresh16", v, 0);
        unlock16(); wr(0, 32'h01A1);
        lp_stop = 1'b1; ticks(2); lp_stop = 1'b0;
        rd(4, v); chk("R7 stop run", v, 2);

        // R8 expiry at timeout 9
        ticks(6); rd(4, v); chk("R7 count 8", v, 8);
        chk("R8 not yet", 32'(rst_req), 0);
        ticks(1); rd(4, v); chk("R8 reached", v, 9);
        chk("R8 registered", 32'(rst_req), 0);
        cyc(1); chk("R8 asserted", 32'(rst_req), 1);
        refresh16(); cyc(3); chk("R8 sticky", 32'(rst_req), 1);

        // Wide-command mode: R3, R6, R9
        do_reset();
        chk("R8 cleared by reset", 32'(rst_req), 0);
        unlock16(); wr(0, 32'h2120);
        rd(0, v); chk("R5 cmd32 set", v, ctl_word(1,0,1,0,1,0,0));
        wr(4, 32'hD928C520); rd(0, v); chk("R3 unlock32", v, ctl_word(1,1,0,0,1,0,0));
        wr(8, 32'd50);
        wr(4, 32'hD928C520); wr(0, 32'h21A0);
        ticks(5); rd(4, v); chk("R7 count wide", v, 5);
        wr(4, 32'hB480A602); rd(4, v); chk("R6 refresh32", v, 0);
        chk("R9 no fault on key", 32'(rst_req), 0);
        wr(4, 32'h0000A602); chk("R9 half in wide", 32'(rst_req), 1);

        // R9 wrong second half
        do_reset();
        wr(4, 32'h0000C520);
        bad = {16'h0, 16'($urandom)};
        if (bad[15:0] == 16'hD928) bad[0] = ~bad[0];
        wr(4, bad); chk("R9 bad second", 32'(rst_req), 1);

        // R9 non-key first write
        do_reset();
        bad = $urandom;
        if (bad[15:0] == 16'hC520 || bad[15:0] == 16'hA602) bad[15:0] = 16'h1234;
        wr(4, bad); chk("R9 bad first", 32'(rst_req), 1);

        // R10 lock-out after update-allow cleared
        do_reset();
        unlock16(); wr(0, 32'h0100);
        rd(0, v); chk("R10 upd cleared", v, 32'h0500);
        unlock16(); rd(0, v); chk("R10 unlock refused", v, 32'h0500);
        chk("R10 no fault", 32'(rst_req), 0);
        wr(8, 32'd5); rd(8, v); chk("R10 tov fixed", v, TOV0);

        // Random timeouts and tick counts
        for (int i = 0; i < 10; i++) begin
            do_reset();
            t = 4 + int'($urandom % 20);
            n = int'($urandom % t);
            unlock16(); wr(8, 32'(t));
            unlock16(); wr(0, 32'h01A0);
            ticks(n); rd(4, v); chk("R7 random count", v, 32'(n));
            chk("R8 random below", 32'(rst_req), 0);
            refresh16(); rd(4, v); chk("R6 random refresh", v, 0);
            ticks(t); cyc(1); chk("R8 random expiry", 32'(rst_req), 1);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule